// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Zone Protection

This block holds a set of address translations that software loads one entry at a time. An entry is written in two halves, and an index picks the entry. The upper half carries the effective page, a page-size code, a valid flag and a byte of storage attributes. When the upper half is written, the current process identifier is latched into the entry. The lower half carries the real page together with the write and execute permissions.

A translation request gives an effective address, the access kind, the privilege level, the current process identifier and a 32-bit zone register. All entries are compared at once, and the lowest-numbered matching entry is used. The zone named in that entry's attributes selects a 2-bit code from the zone register. That code decides the outcome: user access is refused, the entry's own permissions are applied, or read and write are granted outright.

The result appears one cycle after the request. It is either a real address with the granted rights, or a fault code. A miss also loads the fault-address and syndrome registers.

Top module: `tlbz_top`

## Requirements
- R1: After reset, every entry is invalid, `rs_valid` is 0, and `fault_addr` and `fault_syn` are 0. Every lookup then misses.
- R2: `wr_index` selects the entry written. Every index from 0 to ENTRIES-1 is reachable.
- R3: An upper-half write (`wr_hi`=1) works as follows. Bits 9:7 give the size code. Bit 6 is the valid flag. Bits 7:0 are the attributes, and attribute bits 3:0 name the zone. The effective page is the operand with its in-page bits cleared at the decoded size. Clearing bit 6 removes the entry from matching.
- R4: An upper-half write stores `cur_pid` as the entry's identifier. An entry matches only when that identifier equals the request's `cur_pid` or is 0.
- R5: A lower-half write stores the real page from operand bits 31:10. Bit 8 grants write and bit 9 grants execute.
- R6: Size code n covers 1 KiB × 4^n. The match ignores address bits below that size. The real address is the real page above that size joined with the request's offset below it.
- R7: When several valid entries match, the entry with the lowest index is used.
- R8: Zone code 0 (field bits 31-2z:30-2z of `lk_zpr` for zone z) in user mode refuses every access. A fetch faults with code 3 (execute protection). A load or store faults with code 2 (data protection).
- R9: Zone codes 1 and 2, and code 0 in supervisor mode, check the entry. A fetch needs execute permission and otherwise faults with code 3. A data access without write permission is read-only, and a store to it faults with code 2. On any fault, `rs_rd` and `rs_wr` are 0.
- R10: Zone code 3 grants read and write whatever the entry's permission bits are, for every access kind.
- R11: A miss reports code 1 and loads `fault_addr` with the effective address. It loads `fault_syn` with 0x00800000 for a store and 0 for a load or a fetch. Protection faults and hits leave both registers unchanged.
- R12: Each request (`lk_valid`=1) gives exactly one `rs_valid` pulse, on the following cycle. Access codes are: 0 fetch, 1 load, 2 store. Fault codes are: 0 none, 1 miss, 2 data protection, 3 execute protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_hi | input | 1 | 1 selects the upper half, 0 the lower half |
| wr_index | input | IDXW | Entry index for the write |
| wr_data | input | 32 | Write operand |
| cur_pid | input | PIDW | Current process identifier |
| lk_valid | input | 1 | Translation request strobe |
| lk_vaddr | input | 32 | Effective address |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lk_user | input | 1 | 1 for user mode |
| lk_zpr | input | 32 | Zone protection register |
| rs_valid | output | 1 | Result strobe |
| rs_fault | output | 2 | Fault code |
| rs_raddr | output | 32 | Real address |
| rs_rd | output | 1 | Read granted |
| rs_wr | output | 1 | Write granted |
| rs_attr | output | 8 | Attributes of the matched entry |
| fault_addr | output | 32 | Address of the last miss |
| fault_syn | output | 32 | Syndrome of the last miss |

## Verification
The bench builds the block with its default ENTRIES=64 and PIDW=8. With these values the top index, 63, can be written, and an entry at index 1 can be laid over one at index 2 to exercise priority. The size codes used run from 0 (1 KiB) up to 7 (16 MiB), so both the narrowest and the widest offset masks are exercised. The process identifier is switched between a private value and 0 to show that a global entry matches under any identifier.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int ZONES  = 16;
  localparam int ZPR_W  = 2 * ZONES;

  // operand bit positions
  localparam int SZ_HI   = 9;
  localparam int SZ_LO   = 7;
  localparam int VAL_BIT = 6;
  localparam int WR_BIT  = 8;
  localparam int EX_BIT  = 9;

  localparam logic [VA_W-1:0] SYN_STORE_MISS = 32'h0080_0000;
  localparam logic [VA_W-1:0] PG_BASE        = VA_W'(1) << PG_LSB;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_MISS = 2'd1, FLT_DPROT = 2'd2, FLT_XPROT = 2'd3} flt_e;

  typedef struct packed {
    logic            valid;
    logic [VA_W-1:0] epn;
    logic [2:0]      szc;
    logic [7:0]      attr;
    logic [VA_W-1:0] rpn;
    logic            wr_ok;
    logic            ex_ok;
  } ent_t;

  // in-page offset bits for size code n: 1 KiB * 4^n
  function automatic logic [VA_W-1:0] off_mask(input logic [2:0] szc);
    return (PG_BASE << {szc, 1'b0}) - VA_W'(1);
  endfunction
endpackage

// File: rtl/tlbz_store.sv
module tlbz_store
  import tlbz_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PIDW    = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            we_hi,
  input  logic [IDXW-1:0] widx,
  input  logic [VA_W-1:0] wdata,
  input  logic [PIDW-1:0] cur_pid,
  output ent_t            ents [ENTRIES],
  output logic [PIDW-1:0] pids [ENTRIES]
);
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic            sel_hi, sel_lo;
      logic            v_q, v_d;
      logic [VA_W-1:0] epn_q, rpn_q;
      logic [2:0]      szc_q;
      logic [7:0]      attr_q;
      logic            wr_q, ex_q;
      logic [PIDW-1:0] pid_q;

      assign sel_hi = we && we_hi && (widx == IDXW'(g));
      assign sel_lo = we && !we_hi && (widx == IDXW'(g));

      always_comb begin
        v_d = v_q;
        if (sel_hi) v_d = wdata[VAL_BIT];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_d;
      end

      always_ff @(posedge clk) begin
        if (sel_hi) begin
          szc_q  <= wdata[SZ_HI:SZ_LO];
          epn_q  <= wdata & ~off_mask(wdata[SZ_HI:SZ_LO]);
          attr_q <= wdata[7:0];
          pid_q  <= cur_pid;
        end
      end

      always_ff @(posedge clk) begin
        if (sel_lo) begin
          rpn_q <= wdata & ~(PG_BASE - VA_W'(1));
          wr_q  <= wdata[WR_BIT];
          ex_q  <= wdata[EX_BIT];
        end
      end

      assign ents[g] = '{valid: v_q, epn: epn_q, szc: szc_q, attr: attr_q,
                         rpn: rpn_q, wr_ok: wr_q, ex_ok: ex_q};
      assign pids[g] = pid_q;
    end
  endgenerate
endmodule

// File: rtl/tlbz_match.sv
module tlbz_match
  import tlbz_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PIDW    = 8
) (
  input  ent_t            ents [ENTRIES],
  input  logic [PIDW-1:0] pids [ENTRIES],
  input  logic [VA_W-1:0] va,
  input  logic [PIDW-1:0] pid,
  output ent_t            sel   // sel.valid doubles as the hit flag
);
  logic [ENTRIES-1:0] hitv;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hitv[g] = ents[g].valid
                    && (pids[g] == pid || pids[g] == '0)
                    && (((va ^ ents[g].epn) & ~off_mask(ents[g].szc)) == '0);
    end
  endgenerate

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitv[i]) sel = ents[i];
    end
  end
endmodule

// File: rtl/tlbz_perm.sv
module tlbz_perm
  import tlbz_pkg::*;
(
  input  ent_t             ent,
  input  logic [VA_W-1:0]  va,
  input  acc_e             acc,
  input  logic             user,
  input  logic [ZPR_W-1:0] zpr,
  output flt_e             flt,
  output logic             rd,
  output logic             wr,
  output logic [VA_W-1:0]  pa
);
  logic [VA_W-1:0] om;
  logic [3:0]      zn;
  logic [1:0]      zc;

  always_comb begin
    om  = off_mask(ent.szc);
    pa  = (ent.rpn & ~om) | (va & om);
    zn  = ent.attr[3:0];
    zc  = zpr[(ZPR_W - 1) - 2 * int'(zn) -: 2];
    flt = FLT_NONE;
    rd  = 1'b0;
    wr  = 1'b0;
    if (!ent.valid) begin
      flt = FLT_MISS;
    end else if (zc == 2'b11) begin
      rd = 1'b1;
      wr = 1'b1;
    end else if (zc == 2'b00 && user) begin
      flt = (acc == ACC_FETCH) ? FLT_XPROT : FLT_DPROT;
    end else if (acc == ACC_FETCH) begin
      if (ent.ex_ok) begin
        rd = 1'b1;
        wr = ent.wr_ok;
      end else begin
        flt = FLT_XPROT;
      end
    end else if (ent.wr_ok) begin
      rd = 1'b1;
      wr = 1'b1;
    end else if (acc == ACC_STORE) begin
      flt = FLT_DPROT;
    end else begin
      rd = 1'b1;
    end
  end
endmodule

// File: rtl/tlbz_top.sv
module tlbz_top
  import tlbz_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PIDW    = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [IDXW-1:0]  wr_index,
  input  logic [VA_W-1:0]  wr_data,
  input  logic [PIDW-1:0]  cur_pid,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  input  logic [ZPR_W-1:0] lk_zpr,
  output logic             rs_valid,
  output logic [1:0]       rs_fault,
  output logic [VA_W-1:0]  rs_raddr,
  output logic             rs_rd,
  output logic             rs_wr,
  output logic [7:0]       rs_attr,
  output logic [VA_W-1:0]  fault_addr,
  output logic [VA_W-1:0]  fault_syn
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_in_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  ent_t            ents [ENTRIES];
  logic [PIDW-1:0] pids [ENTRIES];
  ent_t            sel;
  flt_e            flt;
  logic            g_rd, g_wr;
  logic [VA_W-1:0] pa;

  tlbz_store #(.ENTRIES(ENTRIES), .PIDW(PIDW)) u_store (
    .clk(clk), .rst_n(rst_in_n), .we(wr_en), .we_hi(wr_hi), .widx(wr_index),
    .wdata(wr_data), .cur_pid(cur_pid), .ents(ents), .pids(pids));

  tlbz_match #(.ENTRIES(ENTRIES), .PIDW(PIDW)) u_match (
    .ents(ents), .pids(pids), .va(lk_vaddr), .pid(cur_pid), .sel(sel));

  tlbz_perm u_perm (
    .ent(sel), .va(lk_vaddr), .acc(acc_e'(lk_acc)), .user(lk_user), .zpr(lk_zpr),
    .flt(flt), .rd(g_rd), .wr(g_wr), .pa(pa));

  // next state
  logic            miss_ld;
  logic [VA_W-1:0] syn_d;
  always_comb begin
    miss_ld = lk_valid && (flt == FLT_MISS);
    syn_d   = (acc_e'(lk_acc) == ACC_STORE) ? SYN_STORE_MISS : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      rs_valid   <= 1'b0;
      fault_addr <= '0;
      fault_syn  <= '0;
    end else begin
      rs_valid <= lk_valid;
      if (miss_ld) begin
        fault_addr <= lk_vaddr;
        fault_syn  <= syn_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      rs_fault <= flt;
      rs_raddr <= pa;
      rs_rd    <= g_rd;
      rs_wr    <= g_wr;
      rs_attr  <= sel.attr;
    end
  end
endmodule

// File: rtl/tlbz_chk.sv
module tlbz_chk
  import tlbz_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic [1:0]      lk_acc,
  input logic            rs_valid,
  input logic [1:0]      rs_fault,
  input logic            rs_rd,
  input logic            rs_wr,
  input logic [VA_W-1:0] fault_addr,
  input logic [VA_W-1:0] fault_syn
);
  assert_result_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  assert_miss_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault == FLT_MISS) |-> fault_addr == $past(lk_vaddr));
  assert_miss_syn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault == FLT_MISS) |->
      fault_syn == (($past(lk_acc) == ACC_STORE) ? SYN_STORE_MISS : '0));
  assert_fault_regs_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_valid && rs_fault == FLT_MISS) |-> ($stable(fault_addr) && $stable(fault_syn)));
  assert_no_grant_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault != FLT_NONE) |-> (!rs_rd && !rs_wr));
  assert_hit_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault == FLT_NONE) |-> rs_rd);
  assert_store_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault == FLT_NONE && $past(lk_acc) == ACC_STORE) |-> rs_wr);
  assert_xprot_only_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault == FLT_XPROT) |-> $past(lk_acc) == ACC_FETCH);
endmodule

bind tlbz_top tlbz_chk u_chk (
  .clk(clk), .rst_n(rst_in_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_acc(lk_acc), .rs_valid(rs_valid), .rs_fault(rs_fault), .rs_rd(rs_rd),
  .rs_wr(rs_wr), .fault_addr(fault_addr), .fault_syn(fault_syn));

// File: tb/tlbz_top_bench.sv
`timescale 1ns/1ps
module tlbz_top_bench;
  localparam int ENTRIES = 64;
  localparam int PIDW    = 8;
  localparam int IDXW    = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_hi = 1'b0;
  logic [IDXW-1:0] wr_index = '0;
  logic [31:0] wr_data = '0;
  logic [PIDW-1:0] cur_pid = '0;
  logic lk_valid = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0, lk_zpr = '0;
  logic [1:0] lk_acc = '0;
  logic rs_valid, rs_rd, rs_wr;
  logic [1:0] rs_fault;
  logic [31:0] rs_raddr, fault_addr, fault_syn;
  logic [7:0] rs_attr;

  always #4 clk = ~clk;

  tlbz_top #(.ENTRIES(ENTRIES), .PIDW(PIDW)) u_tlbz_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_index(wr_index),
    .wr_data(wr_data), .cur_pid(cur_pid), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_user(lk_user), .lk_zpr(lk_zpr), .rs_valid(rs_valid),
    .rs_fault(rs_fault), .rs_raddr(rs_raddr), .rs_rd(rs_rd), .rs_wr(rs_wr),
    .rs_attr(rs_attr), .fault_addr(fault_addr), .fault_syn(fault_syn));

  typedef struct {
    logic [1:0]  flt;
    logic [31:0] pa;
    logic        rd, wr;
    logic [31:0] fa, syn;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_n && rs_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R12", "unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rs_fault == e.flt, e.tag, "fault", 32'(rs_fault), 32'(e.flt));
        if (e.flt == 2'd0) chk(rs_raddr == e.pa, e.tag, "raddr", rs_raddr, e.pa);
        chk(rs_rd == e.rd, e.tag, "rd", 32'(rs_rd), 32'(e.rd));
        chk(rs_wr == e.wr, e.tag, "wr", 32'(rs_wr), 32'(e.wr));
        chk(fault_addr == e.fa, e.tag, "fault_addr", fault_addr, e.fa);
        chk(fault_syn == e.syn, e.tag, "fault_syn", fault_syn, e.syn);
      end
    end
  end

  task automatic wr(input logic hi, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_index = IDXW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push the expected item, then issue the request
  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                        input logic [31:0] zpr, input logic [1:0] ef, input logic [31:0] epa,
                        input logic erd, input logic ewr, input logic [31:0] efa,
                        input logic [31:0] esyn, input string tag);
    exp_t e;
    e.flt = ef; e.pa = epa; e.rd = erd; e.wr = ewr; e.fa = efa; e.syn = esyn; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = usr; lk_zpr = zpr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", "timeout", 32'd1, 32'd0);
      summary();
    end
  end

  localparam logic [1:0] F = 2'd0, L = 2'd1, S = 2'd2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rs_valid, "R1", "rs_valid", 32'(rs_valid), 32'd0);
    chk(fault_addr == 0, "R1", "fault_addr", fault_addr, 32'd0);
    chk(fault_syn == 0, "R1", "fault_syn", fault_syn, 32'd0);
    lookup(32'h0000_1000, L, 1, 32'h0, 2'd1, 0, 0, 0, 32'h0000_1000, 0, "R1 R11 empty miss");

    cur_pid = 8'd5;
    wr(1, 2, 32'h0001_0CC1);   // 4 KiB, valid, zone 1; epn gets aligned
    wr(0, 2, 32'h8000_0300);   // write + execute
    lookup(32'h0001_0ABC, L, 1, 32'h1000_0000, 2'd0, 32'h8000_0ABC, 1, 1, 32'h0000_1000, 0, "R3 R5 R6 hit");
    lookup(32'h0001_1000, S, 1, 32'h1000_0000, 2'd1, 0, 0, 0, 32'h0001_1000, 32'h0080_0000, "R6 R11 store miss");
    cur_pid = 8'd6;
    lookup(32'h0001_0ABC, L, 1, 32'h1000_0000, 2'd1, 0, 0, 0, 32'h0001_0ABC, 0, "R4 pid mismatch");

    cur_pid = 8'd0;
    wr(1, 3, 32'h0002_0142);   // 16 KiB, valid, zone 2, global
    wr(0, 3, 32'h4000_0200);   // execute only
    cur_pid = 8'd6;
    lookup(32'h0002_3456, L, 1, 32'h0400_0000, 2'd0, 32'h4000_3456, 1, 0, 32'h0001_0ABC, 0, "R4 R9 global read-only");
    lookup(32'h0002_3456, S, 1, 32'h0400_0000, 2'd2, 0, 0, 0, 32'h0001_0ABC, 0, "R9 R11 store dprot");
    lookup(32'h0002_3456, F, 1, 32'h0400_0000, 2'd0, 32'h4000_3456, 1, 0, 32'h0001_0ABC, 0, "R9 fetch exec ok");
    lookup(32'h0002_3456, S, 1, 32'h0C00_0000, 2'd0, 32'h4000_3456, 1, 1, 32'h0001_0ABC, 0, "R10 zone3 store");
    lookup(32'h0002_3456, S, 1, 32'h0, 2'd2, 0, 0, 0, 32'h0001_0ABC, 0, "R8 user store");
    lookup(32'h0002_3456, L, 1, 32'h0, 2'd2, 0, 0, 0, 32'h0001_0ABC, 0, "R8 user load");
    lookup(32'h0002_3456, F, 1, 32'h0, 2'd3, 0, 0, 0, 32'h0001_0ABC, 0, "R8 user fetch");
    lookup(32'h0002_3456, L, 0, 32'h0, 2'd0, 32'h4000_3456, 1, 0, 32'h0001_0ABC, 0, "R9 sup load zone0");
    lookup(32'h0002_3456, S, 0, 32'h0, 2'd2, 0, 0, 0, 32'h0001_0ABC, 0, "R9 sup store zone0");

    cur_pid = 8'd5;
    wr(1, 4, 32'h0003_0041);   // 1 KiB, valid, zone 1
    wr(0, 4, 32'h2000_0100);   // write, no execute
    lookup(32'h0003_03FF, F, 0, 32'h2000_0000, 2'd3, 0, 0, 0, 32'h0001_0ABC, 0, "R9 fetch xprot");
    lookup(32'h0003_03FF, L, 0, 32'h2000_0000, 2'd0, 32'h2000_03FF, 1, 1, 32'h0001_0ABC, 0, "R6 1KiB hit");
    lookup(32'h0003_03FF, F, 0, 32'h3000_0000, 2'd0, 32'h2000_03FF, 1, 1, 32'h0001_0ABC, 0, "R10 zone3 fetch");
    lookup(32'h0003_0400, F, 0, 32'h3000_0000, 2'd1, 0, 0, 0, 32'h0003_0400, 0, "R6 R11 fetch miss");

    wr(1, 1, 32'h0001_01C1);   // 64 KiB overlapping entry 2
    wr(0, 1, 32'h9000_0300);
    lookup(32'h0001_0ABC, L, 1, 32'h1000_0000, 2'd0, 32'h9000_0ABC, 1, 1, 32'h0003_0400, 0, "R7 lowest index");
    wr(1, 1, 32'h0001_0181);   // valid cleared
    lookup(32'h0001_0ABC, L, 1, 32'h1000_0000, 2'd0, 32'h8000_0ABC, 1, 1, 32'h0003_0400, 0, "R3 invalidate");

    wr(1, 10, 32'h0F00_03C3);  // 16 MiB, valid, zone 3
    wr(0, 10, 32'hA500_0000);  // no permission bits
    lookup(32'h0FAB_CDEF, S, 1, 32'h0300_0000, 2'd0, 32'hA5AB_CDEF, 1, 1, 32'h0003_0400, 0, "R6 R10 16MiB");

    wr(1, ENTRIES - 1, 32'h0005_0041);
    wr(0, ENTRIES - 1, 32'h1234_0300);
    lookup(32'h0005_0123, L, 1, 32'h1000_0000, 2'd0, 32'h1234_0123, 1, 1, 32'h0003_0400, 0, "R2 top index");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R12", "pending results", 32'(sbq.size()), 32'd0);
    chk(!rs_valid, "R12", "idle rs_valid", 32'(rs_valid), 32'd0);
    done = 1'b1;
    summary();
  end
endmodule